// File: doc/BRIEF.md
# Register Rename Mapper with Per-Instruction Checkpoints

The block sits at the dispatch stage of an out-of-order integer core. Each cycle it takes up to `WIDTH` instructions. Every instruction carries two source specifiers and one destination specifier. For each one it returns the physical tags of its sources, a freshly allocated physical tag for its destination, and an identifier for its in-flight entry. There are 32 architectural registers, backed by a pool of `NUM_PHYS` physical registers. Because every new destination goes to an unused physical register, write-after-read and write-after-write hazards disappear.

For every in-flight instruction, the block stores the full map as it stood right after that instruction. A redirect (branch mispredict or exception) names the redirecting instruction's identifier. In one cycle the live map returns to that stored map, and every younger instruction is discarded. The free list is not kept as separate state. Each cycle it is derived from the speculative map and from the previous mappings still pinned by instructions that have not yet retired. As a result, retirement and rollback release registers simply by shrinking the window of live entries.

Architectural register 31 is the zero register. It stays on physical register 31, is never renamed and never takes a free register.

Top module: `rename_mapper`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and `free_cnt_o` equals `NUM_PHYS - 32`.
- R2: A valid slot's source tag equals the physical register mapped to that specifier at the start of the cycle, unless R4 applies.
- R3: Slots whose destination is not 31 receive the lowest-numbered free physical registers, in ascending slot order, and each such tag becomes unavailable from the next cycle.
- R4: Within a group, a source of slot k sees the destination tag of the highest-numbered earlier slot j < k that writes the same architectural register. A later write to the same register wins in the resulting map.
- R5: Specifier 31 always yields tag 31. A destination of 31 reports tag 31 and does not reduce the free count.
- R6: `disp_ready_o` is low when the free count is below the number of destinations in the group, or the free entry count is below the number of valid slots. A group presented while `disp_ready_o` is low leaves the map, the free count and the identifiers unchanged.
- R7: The valid slots of an accepted group receive consecutive entry identifiers in slot order, starting at the position following the youngest live entry, modulo `DEPTH`.
- R8: `retire_cnt_i` retires that many of the oldest entries. The physical register each retired entry's destination held before it is returned to the free list and counted in `free_cnt_o` the next cycle.
- R9: With `redirect_i` high, the map becomes, on the next cycle, the map as it stood right after the instruction `redirect_id_i`. All younger entries are discarded, and the next identifier issued follows the redirecting one.
- R10: A rollback returns to the free list every physical register allocated by the discarded instructions.
- R11: While `redirect_i` is high, `disp_ready_o` is low and the presented group is not accepted.
- R12: `free_cnt_o` equals the number of physical registers that are neither mapped nor pinned by a live entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| disp_valid_i | input | WIDTH | Per-slot instruction valid |
| disp_src_a_i | input | WIDTH*5 | First source specifier per slot |
| disp_src_b_i | input | WIDTH*5 | Second source specifier per slot |
| disp_dst_i | input | WIDTH*5 | Destination specifier per slot (31 = none) |
| disp_ready_o | output | 1 | Group accepted this cycle when high |
| src_a_tag_o | output | WIDTH*PW | Physical tag of first source |
| src_b_tag_o | output | WIDTH*PW | Physical tag of second source |
| dst_tag_o | output | WIDTH*PW | Allocated destination tag |
| inst_id_o | output | WIDTH*IW | Entry identifier per slot |
| retire_cnt_i | input | RW | Number of oldest entries retiring |
| redirect_i | input | 1 | Redirect: roll back to redirect_id_i |
| redirect_id_i | input | IW | Identifier of the redirecting instruction |
| free_cnt_o | output | CNTW | Number of free physical registers |

## Verification
The bench builds the block with `NUM_PHYS = 40`, `DEPTH = 8` and `WIDTH = 4`. That leaves only eight free registers after reset, so both stall conditions occur within a few groups. The identifiers also wrap around the entry ring many times, and a full ring coincides with redirects. A long stream of mixed groups, retirements and rollbacks is driven against an arithmetic model of the map and free set in the bench. Sources and destinations are drawn from a handful of registers plus 31, so that same-group dependencies and multi-level rollbacks happen constantly.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int ARCH_REGS = 32;
  localparam int AREG_W    = 5;
  localparam logic [AREG_W-1:0] ZERO_REG = 5'd31;
endpackage

// File: rtl/rn_free_pick.sv
module rn_free_pick #(
  parameter  int NUM_PHYS = 80,
  parameter  int WIDTH    = 4,
  localparam int PW       = $clog2(NUM_PHYS),
  localparam int CNTW     = $clog2(NUM_PHYS + 1)
) (
  input  logic [NUM_PHYS-1:0]        busy_i,
  output logic [CNTW-1:0]            free_cnt_o,
  output logic [WIDTH-1:0][PW-1:0]   pick_o
);
  logic [NUM_PHYS-1:0] avail;

  // WIDTH chained lowest-set-bit searches
  always_comb begin
    avail  = ~busy_i;
    pick_o = '0;
    for (int j = 0; j < WIDTH; j++) begin
      for (int p = NUM_PHYS - 1; p >= 0; p--)
        if (avail[p]) pick_o[j] = PW'(p);
      avail[pick_o[j]] = 1'b0;
    end
  end

  assign free_cnt_o = CNTW'($countones(~busy_i));
endmodule

// File: rtl/rn_ckpt_ring.sv
module rn_ckpt_ring import rn_pkg::*; #(
  parameter  int NUM_PHYS = 80,
  parameter  int WIDTH    = 4,
  parameter  int DEPTH    = 16,
  localparam int PW       = $clog2(NUM_PHYS),
  localparam int IW       = $clog2(DEPTH),
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int RW       = $clog2(WIDTH + 1)
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic [WIDTH-1:0]                         slot_valid_i,
  input  logic                                     push_en_i,
  input  logic [WIDTH-1:0][ARCH_REGS-1:0][PW-1:0]  push_snap_i,
  input  logic [WIDTH-1:0][PW-1:0]                 push_old_i,
  input  logic [RW-1:0]                            retire_cnt_i,
  input  logic                                     redirect_i,
  input  logic [IW-1:0]                            redirect_id_i,
  output logic [WIDTH-1:0][IW-1:0]                 slot_id_o,
  output logic [CW-1:0]                            used_o,
  output logic [ARCH_REGS-1:0][PW-1:0]             restore_map_o,
  output logic [NUM_PHYS-1:0]                      pinned_o
);
  logic [ARCH_REGS-1:0][PW-1:0] snap_q [DEPTH];
  logic [PW-1:0]                old_q  [DEPTH];
  logic [IW-1:0]                head_q, tail_q;
  logic [CW-1:0]                used_q;
  logic [RW-1:0]                n_push;

  always_comb begin
    logic [IW-1:0] off;
    off = '0;
    for (int k = 0; k < WIDTH; k++) begin
      slot_id_o[k] = tail_q + off;
      if (slot_valid_i[k]) off = off + 1'b1;
    end
  end

  assign n_push        = push_en_i ? RW'($countones(slot_valid_i)) : '0;
  assign used_o        = used_q;
  assign restore_map_o = snap_q[redirect_id_i];

  // Prior mappings of live entries stay reserved until retirement
  always_comb begin
    pinned_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      logic [IW-1:0] age;
      age = IW'(e) - head_q;
      if (CW'(age) < used_q) pinned_o[old_q[e]] = 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < WIDTH; k++)
      if (push_en_i && slot_valid_i[k]) begin
        snap_q[slot_id_o[k]] <= push_snap_i[k];
        old_q[slot_id_o[k]]  <= push_old_i[k];
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      used_q <= '0;
    end else begin
      head_q <= head_q + IW'(retire_cnt_i);
      if (redirect_i) begin
        tail_q <= redirect_id_i + 1'b1;
        used_q <= CW'(IW'(redirect_id_i - head_q)) + 1'b1 - CW'(retire_cnt_i);
      end else begin
        tail_q <= tail_q + IW'(n_push);
        used_q <= used_q + CW'(n_push) - CW'(retire_cnt_i);
      end
    end
  end

  assert_ring_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_q <= CW'(DEPTH));
  assert_retire_live_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(retire_cnt_i) <= used_q);
  assert_redirect_live_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |-> CW'(IW'(redirect_id_i - head_q)) < used_q);
endmodule

// File: rtl/rename_mapper.sv
module rename_mapper import rn_pkg::*; #(
  parameter  int NUM_PHYS = 80,
  parameter  int WIDTH    = 4,
  parameter  int DEPTH    = 16,
  localparam int PW       = $clog2(NUM_PHYS),
  localparam int IW       = $clog2(DEPTH),
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int RW       = $clog2(WIDTH + 1),
  localparam int CNTW     = $clog2(NUM_PHYS + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [WIDTH-1:0]               disp_valid_i,
  input  logic [WIDTH-1:0][AREG_W-1:0]   disp_src_a_i,
  input  logic [WIDTH-1:0][AREG_W-1:0]   disp_src_b_i,
  input  logic [WIDTH-1:0][AREG_W-1:0]   disp_dst_i,
  output logic                           disp_ready_o,
  output logic [WIDTH-1:0][PW-1:0]       src_a_tag_o,
  output logic [WIDTH-1:0][PW-1:0]       src_b_tag_o,
  output logic [WIDTH-1:0][PW-1:0]       dst_tag_o,
  output logic [WIDTH-1:0][IW-1:0]       inst_id_o,
  input  logic [RW-1:0]                  retire_cnt_i,
  input  logic                           redirect_i,
  input  logic [IW-1:0]                  redirect_id_i,
  output logic [CNTW-1:0]                free_cnt_o
);
  logic [ARCH_REGS-1:0][PW-1:0]          map_q;
  logic [WIDTH:0][ARCH_REGS-1:0][PW-1:0] chain;
  logic [ARCH_REGS-1:0][PW-1:0]          restore_map;
  logic [WIDTH-1:0][PW-1:0]              pick, new_tag, old_tag;
  logic [WIDTH-1:0]                      has_dst;
  logic [NUM_PHYS-1:0]                   map_busy, pinned, busy;
  logic [RW-1:0]                         rank, n_valid;
  logic [CW-1:0]                         used;
  logic                                  fire;

  always_comb begin
    map_busy = '0;
    for (int a = 0; a < ARCH_REGS; a++) map_busy[map_q[a]] = 1'b1;
  end
  assign busy = map_busy | pinned;

  rn_free_pick #(.NUM_PHYS(NUM_PHYS), .WIDTH(WIDTH)) u_pick (
    .busy_i     (busy),
    .free_cnt_o (free_cnt_o),
    .pick_o     (pick)
  );

  // Serial map update across slots gives in-group forwarding
  always_comb begin
    chain[0] = map_q;
    rank     = '0;
    for (int k = 0; k < WIDTH; k++) begin
      chain[k+1]     = chain[k];
      src_a_tag_o[k] = chain[k][disp_src_a_i[k]];
      src_b_tag_o[k] = chain[k][disp_src_b_i[k]];
      old_tag[k]     = chain[k][disp_dst_i[k]];
      has_dst[k]     = disp_valid_i[k] && (disp_dst_i[k] != ZERO_REG);
      new_tag[k]     = pick[rank];
      if (has_dst[k]) begin
        chain[k+1][disp_dst_i[k]] = pick[rank];
        rank = rank + 1'b1;
      end
      dst_tag_o[k] = has_dst[k] ? new_tag[k] : old_tag[k];
    end
  end

  assign n_valid      = RW'($countones(disp_valid_i));
  assign disp_ready_o = !redirect_i && (free_cnt_o >= CNTW'(rank)) &&
                        ((CW'(DEPTH) - used) >= CW'(n_valid));
  assign fire         = disp_ready_o && (disp_valid_i != '0);

  rn_ckpt_ring #(.NUM_PHYS(NUM_PHYS), .WIDTH(WIDTH), .DEPTH(DEPTH)) u_ring (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .slot_valid_i  (disp_valid_i),
    .push_en_i     (fire),
    .push_snap_i   (chain[WIDTH:1]),
    .push_old_i    (old_tag),
    .retire_cnt_i  (retire_cnt_i),
    .redirect_i    (redirect_i),
    .redirect_id_i (redirect_id_i),
    .slot_id_o     (inst_id_o),
    .used_o        (used),
    .restore_map_o (restore_map),
    .pinned_o      (pinned)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < ARCH_REGS; a++) map_q[a] <= PW'(a);
    end else if (redirect_i) begin
      map_q <= restore_map;
    end else if (fire) begin
      map_q <= chain[WIDTH];
    end
  end

  assert_zero_fixed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_q[ZERO_REG] == PW'(ZERO_REG));
  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire && !redirect_i |=> $stable(map_q));
  assert_redirect_block_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |-> !disp_ready_o);

  for (genvar k = 0; k < WIDTH; k++) begin : g_alloc_chk
    assert_alloc_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire && has_dst[k] && !redirect_i |=> busy[$past(new_tag[k])]);
  end
endmodule

// File: tb/rename_mapper_tb.sv
module rename_mapper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 40;
  localparam int W  = 4;
  localparam int D  = 8;
  localparam int PW = $clog2(P);
  localparam int IW = $clog2(D);
  localparam int RW = $clog2(W + 1);
  localparam int CNTW = $clog2(P + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0]        disp_valid = '0;
  logic [W-1:0][4:0]   src_a = '0, src_b = '0, dst = '0;
  logic                disp_ready;
  logic [W-1:0][PW-1:0] a_tag, b_tag, d_tag;
  logic [W-1:0][IW-1:0] iid;
  logic [RW-1:0]       retire_cnt = '0;
  logic                redirect = 1'b0;
  logic [IW-1:0]       redirect_id = '0;
  logic [CNTW-1:0]     free_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_mapper #(.NUM_PHYS(P), .WIDTH(W), .DEPTH(D)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_valid_i(disp_valid), .disp_src_a_i(src_a), .disp_src_b_i(src_b),
    .disp_dst_i(dst), .disp_ready_o(disp_ready),
    .src_a_tag_o(a_tag), .src_b_tag_o(b_tag), .dst_tag_o(d_tag), .inst_id_o(iid),
    .retire_cnt_i(retire_cnt), .redirect_i(redirect), .redirect_id_i(redirect_id),
    .free_cnt_o(free_cnt)
  );

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  int mmap [32];
  bit mfree [P];
  int rdst [D], rnew [D], rold [D];
  int mhead = 0, mtail = 0;
  string src_ctx = "R2";
  string fc_ctx  = "R12";

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_free();
    int n = 0;
    for (int p = 0; p < P; p++) if (mfree[p]) n++;
    return n;
  endfunction

  task automatic step(input logic [W-1:0] v, input logic [W-1:0][4:0] a,
                      input logic [W-1:0][4:0] b, input logic [W-1:0][4:0] d,
                      input int ret, input bit rd, input int roff);
    int nd, nv, inflight;
    bit er;
    bit wrote [32];
    @(negedge clk);
    disp_valid  = v; src_a = a; src_b = b; dst = d;
    retire_cnt  = RW'(ret);
    redirect    = rd;
    redirect_id = IW'((mhead + roff) % D);
    #1;
    check(fc_ctx, int'(free_cnt), model_free());
    nd = 0; nv = 0;
    for (int k = 0; k < W; k++) if (v[k]) begin nv++; if (d[k] != 5'd31) nd++; end
    inflight = mtail - mhead;
    er = !rd && (model_free() >= nd) && ((D - inflight) >= nv);
    check(rd ? "R11" : "R6", int'(disp_ready), int'(er));
    for (int r = 0; r < 32; r++) wrote[r] = 1'b0;
    if (er && v != '0) begin
      for (int k = 0; k < W; k++) if (v[k]) begin
        check(a[k] == 5'd31 ? "R5" : (wrote[a[k]] ? "R4" : src_ctx), int'(a_tag[k]), mmap[a[k]]);
        check(b[k] == 5'd31 ? "R5" : (wrote[b[k]] ? "R4" : src_ctx), int'(b_tag[k]), mmap[b[k]]);
        check("R7", int'(iid[k]), mtail % D);
        if (d[k] != 5'd31) begin
          int p = 0;
          while (!mfree[p]) p++;
          check("R3", int'(d_tag[k]), p);
          mfree[p] = 1'b0;
          rold[mtail % D] = mmap[d[k]];
          rnew[mtail % D] = p;
          mmap[d[k]] = p;
          wrote[d[k]] = 1'b1;
        end else begin
          check("R5", int'(d_tag[k]), 31);
          rold[mtail % D] = 31;
          rnew[mtail % D] = 31;
        end
        rdst[mtail % D] = d[k];
        mtail++;
      end
    end
    if (rd) begin
      for (int j = mtail - 1; j > mhead + roff; j--) begin
        if (rdst[j % D] != 31) begin
          mmap[rdst[j % D]] = rold[j % D];
          mfree[rnew[j % D]] = 1'b1;
        end
      end
      mtail = mhead + roff + 1;
    end
    for (int j = 0; j < ret; j++) begin
      if (rdst[mhead % D] != 31) mfree[rold[mhead % D]] = 1'b1;
      mhead++;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    logic [W-1:0][4:0] ga, gb, gd;
    for (int i = 0; i < 32; i++) mmap[i] = i;
    for (int p = 0; p < P; p++) mfree[p] = (p >= 32);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", int'(free_cnt), P - 32);

    // R1: identity map read back
    src_ctx = "R1";
    ga = {5'd3, 5'd2, 5'd1, 5'd0};
    gb = {5'd31, 5'd30, 5'd29, 5'd28};
    gd = {5'd31, 5'd31, 5'd31, 5'd31};
    step(4'hF, ga, gb, gd, 0, 1'b0, 0);
    src_ctx = "R2";

    // R4: forwarding of repeated destination inside a group
    ga = {5'd3, 5'd3, 5'd3, 5'd3};
    gb = {5'd4, 5'd4, 5'd3, 5'd4};
    gd = {5'd31, 5'd4, 5'd3, 5'd3};
    step(4'hF, ga, gb, gd, 0, 1'b0, 0);

    // R9/R10: roll back to the first instruction of the second group
    step(4'hF, ga, gb, gd, 0, 1'b1, 4);
    fc_ctx = "R10";
    src_ctx = "R9";
    gd = {5'd31, 5'd31, 5'd31, 5'd31};
    step(4'b0011, ga, gb, gd, 0, 1'b0, 0);
    fc_ctx = "R12";
    src_ctx = "R2";

    for (int it = 0; it < 3000; it++) begin
      logic [W-1:0] v;
      int inflight, ret, roff;
      bit rd;
      for (int k = 0; k < W; k++) begin
        int x;
        x = $urandom % 9; ga[k] = (x == 8) ? 5'd31 : 5'(x);
        x = $urandom % 9; gb[k] = (x == 8) ? 5'd31 : 5'(x);
        x = $urandom % 9; gd[k] = (x == 8) ? 5'd31 : 5'(x);
      end
      v = W'($urandom % 16);
      inflight = mtail - mhead;
      rd = (inflight > 0) && ($urandom % 10 == 0);
      roff = rd ? int'($urandom % inflight) : 0;
      ret = rd ? 0 : int'($urandom % ((inflight < W ? inflight : W) + 1));
      step(v, ga, gb, gd, ret, rd, roff);
    end

    // R8: drain all live entries
    while (mtail - mhead > 0) begin
      int n;
      n = (mtail - mhead < W) ? mtail - mhead : W;
      step('0, ga, gb, gd, n, 1'b0, 0);
    end
    fc_ctx = "R8";
    step('0, ga, gb, gd, 0, 1'b0, 0);
    check("R8", int'(free_cnt), P - 32);
    finish_run();
  end
endmodule